// File: doc/BRIEF.md
# TLB Miss Refill Walker

This block runs after the main translation lookaside buffer has reported a miss for a load, a store or an instruction fetch. It forms the virtual address of the page-table entry that describes the missing page. It translates that address through the same TLB, over a lookup port on which no nested refill is allowed. It then fetches the 32-bit entry over a single request/response memory port and writes it into one of the four refill ways, chosen by round-robin replacement.

Once the entry is installed, the walker checks the faulting access against it: first privilege, then access rights. It returns either the physical address or a fault code that tells load, store and fetch apart. The TLB array, the page-table base register, the ring-to-ASID register and the memory system all sit outside the block. One walk is in flight at a time.

Top module: `pte_refill_walker`

## Requirements
- R1: `busy` rises in the cycle after `req_valid` is accepted while idle, and stays high until the cycle after the single-cycle `done` pulse. A request presented while `busy` is high is ignored: it produces no lookup, no memory read, no refill write and no result.
- R2: In the cycle after acceptance, `lkp_valid` is high for exactly one cycle. In that cycle `lkp_vaddr` equals (`pt_base` OR (faulting address shifted right by 10)) with bits 1:0 cleared.
- R3: If the lookup reports no hit, the walk ends with the miss code (1 for fetch, 2 for load or store). No memory read and no refill write take place.
- R4: On a lookup hit, one `mem_req` pulse is issued with `mem_addr` equal to `lkp_paddr`. A response with `mem_rsp_err` set ends the walk with the miss code and no refill write.
- R5: The refill write carries these fields:
  - vpn: the faulting address with bits 11:0 cleared.
  - ppn: the entry with bits 11:0 cleared.
  - attr: entry bits 3:0.
  - asid: the byte of `rasid` picked by the ring in entry bits 5:4, where ring k selects bits 8k+7:8k.
- R6: The refill way comes from a counter that steps before it is used and wraps modulo 4. After reset the first refill goes to way 1, then 2, 3, 0, and so on. Walks without a refill leave the counter unchanged.
- R7: `excvaddr` is loaded with the faulting address on every refill. Walks that end without a refill leave it unchanged. It reads 0 after reset.
- R8: If the entry ring is numerically below `req_priv`, the result is a privilege fault: 3 for fetch, 4 for load or store. This check comes before the rights check.
- R9: The attribute grants rights as follows:
  - Values below 12 always grant read; in that range bit 0 grants execute and bit 1 grants write.
  - Value 13 grants read and write.
  - Every other value grants nothing.
  - A denied access reports 5 (load), 6 (store) or 7 (fetch).
- R10: For loads and stores the execute right is ignored. For fetches the read and write rights are ignored. Access kind encoding: 0 load, 1 store, 2 fetch.
- R11: A granted access returns fault code 0 and `paddr` equal to the ppn with bits 11:0 taken from the faulting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | TLB miss to be walked |
| req_vaddr | input | 32 | Faulting virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege ring |
| pt_base | input | 32 | Page-table virtual base |
| rasid | input | 32 | Four ASID bytes, one per ring |
| busy | output | 1 | Walk in progress |
| lkp_valid | output | 1 | No-refill lookup of the entry address |
| lkp_vaddr | output | 32 | Entry virtual address |
| lkp_hit | input | 1 | Lookup hit, same cycle |
| lkp_paddr | input | 32 | Lookup physical address, same cycle |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 32 | Entry physical address |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | 32 | Page-table entry |
| mem_rsp_err | input | 1 | Read failed |
| tlb_wr_en | output | 1 | Refill write strobe |
| tlb_wr_way | output | 2 | Refill way |
| tlb_wr_vpn | output | 32 | Virtual page |
| tlb_wr_ppn | output | 32 | Physical page |
| tlb_wr_asid | output | 8 | Installed ASID |
| tlb_wr_attr | output | 4 | Installed attribute |
| excvaddr | output | 32 | Exception virtual address |
| done | output | 1 | Result valid pulse |
| fault_code | output | 3 | 0 ok, 1..7 as in R3, R8, R9 |
| paddr | output | 32 | Physical address when fault_code is 0 |

## Verification
The assertions assume that the lookup port answers in the same cycle that `lkp_valid` is high, and that memory returns exactly one response per `mem_req` and never answers without one. The bench models both sides under these rules. Its lookup model adds a fixed offset to the address it receives, and its memory model answers one cycle after each request. Extra requests are injected only while a walk is running, which is exactly the situation where they must be ignored.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_LKP, ST_REQ, ST_WAIT, ST_INST, ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_IMISS      = 3'd1,
        FLT_DMISS      = 3'd2,
        FLT_IPRIV      = 3'd3,
        FLT_DPRIV      = 3'd4,
        FLT_LOAD_DENY  = 3'd5,
        FLT_STORE_DENY = 3'd6,
        FLT_FETCH_DENY = 3'd7
    } fault_e;

    localparam int ATTR_W = 4;
    localparam int RING_W = 2;
endpackage

// File: rtl/pw_pte_addr.sv
`timescale 1ns/1ps
module pw_pte_addr #(
    parameter int AW    = 32,
    parameter int SHIFT = 10,
    parameter int ALIGN = 2
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] va,
    output logic [AW-1:0] pte_va
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN) - AW'(1));

    always_comb begin
        pte_va = (base | (va >> SHIFT)) & ALIGN_MASK;
    end
endmodule

// File: rtl/pw_rights.sv
`timescale 1ns/1ps
module pw_rights
    import pw_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  acc_e              kind,
    output logic              granted
);
    logic rd, wr, ex;

    always_comb begin
        rd = 1'b0;
        wr = 1'b0;
        ex = 1'b0;
        if (attr < 4'd12) begin
            rd = 1'b1;
            ex = attr[0];
            wr = attr[1];
        end else if (attr == 4'd13) begin
            rd = 1'b1;
            wr = 1'b1;
        end
        case (kind)
            ACC_LOAD:  granted = rd;
            ACC_STORE: granted = wr;
            ACC_FETCH: granted = ex;
            default:   granted = 1'b0;
        endcase
    end

    always_comb begin
        if (attr == 4'd12 || attr == 4'd14 || attr == 4'd15)
            a_r9_reserved_denied: assert (!granted);
    end
endmodule

// File: rtl/pw_victim.sv
`timescale 1ns/1ps
module pw_victim #(
    parameter int NWAYS = 4,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] way_q, way_d, nxt;

    always_comb begin
        nxt   = (way_q == WAY_W'(NWAYS - 1)) ? '0 : way_q + 1'b1;
        way_d = adv ? nxt : way_q;
        way   = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) way_q <= '0;
        else        way_q <= way_d;
    end

    a_r6_way_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> way_q == $past(nxt));
    a_r6_way_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(way_q));
endmodule

// File: rtl/pte_refill_walker.sv
`timescale 1ns/1ps
module pte_refill_walker
    import pw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_SHIFT = 10,
    parameter int NWAYS     = 4,
    parameter int ASID_W    = 8,
    localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int RASID_W  = ASID_W * (1 << RING_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic [RING_W-1:0]  req_priv,
    input  logic [AW-1:0]      pt_base,
    input  logic [RASID_W-1:0] rasid,
    output logic               busy,
    output logic               lkp_valid,
    output logic [AW-1:0]      lkp_vaddr,
    input  logic               lkp_hit,
    input  logic [AW-1:0]      lkp_paddr,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [AW-1:0]      mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               tlb_wr_en,
    output logic [WAY_W-1:0]   tlb_wr_way,
    output logic [AW-1:0]      tlb_wr_vpn,
    output logic [AW-1:0]      tlb_wr_ppn,
    output logic [ASID_W-1:0]  tlb_wr_asid,
    output logic [ATTR_W-1:0]  tlb_wr_attr,
    output logic [AW-1:0]      excvaddr,
    output logic               done,
    output logic [2:0]         fault_code,
    output logic [AW-1:0]      paddr
);
    localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     va;
        acc_e              kind;
        logic [RING_W-1:0] priv;
        logic [AW-1:0]     pte_pa;
        logic [AW-1:0]     pte;
        fault_e            code;
        logic [AW-1:0]     pa;
        logic [AW-1:0]     excv;
    } walk_regs_t;

    walk_regs_t r_q, r_d;
    logic              adv;
    logic              granted;
    logic [RING_W-1:0] ring;
    fault_e            miss_code;

    pw_pte_addr #(.AW(AW), .SHIFT(PTE_SHIFT), .ALIGN(2)) u_addr (
        .base   (pt_base),
        .va     (r_q.va),
        .pte_va (lkp_vaddr)
    );

    pw_rights u_rights (
        .attr    (r_q.pte[ATTR_W-1:0]),
        .kind    (r_q.kind),
        .granted (granted)
    );

    pw_victim #(.NWAYS(NWAYS)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .way   (tlb_wr_way)
    );

    always_comb begin
        ring        = r_q.pte[ATTR_W +: RING_W];
        miss_code   = (r_q.kind == ACC_FETCH) ? FLT_IMISS : FLT_DMISS;
        tlb_wr_vpn  = r_q.va & PAGE_MASK;
        tlb_wr_ppn  = r_q.pte & PAGE_MASK;
        tlb_wr_attr = r_q.pte[ATTR_W-1:0];
        tlb_wr_asid = rasid[ring*ASID_W +: ASID_W];
    end

    always_comb begin
        r_d       = r_q;
        adv       = 1'b0;
        lkp_valid = 1'b0;
        mem_req   = 1'b0;
        tlb_wr_en = 1'b0;
        done      = 1'b0;
        case (r_q.st)
            ST_IDLE: if (req_valid) begin
                r_d.st   = ST_LKP;
                r_d.va   = req_vaddr;
                r_d.kind = acc_e'(req_kind);
                r_d.priv = req_priv;
                r_d.code = FLT_NONE;
                r_d.pa   = '0;
            end
            ST_LKP: begin
                lkp_valid = 1'b1;
                if (lkp_hit) begin
                    r_d.pte_pa = lkp_paddr;
                    r_d.st     = ST_REQ;
                end else begin
                    r_d.code = miss_code;
                    r_d.st   = ST_DONE;
                end
            end
            ST_REQ: begin
                mem_req = 1'b1;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: if (mem_rsp_valid) begin
                if (mem_rsp_err) begin
                    r_d.code = miss_code;
                    r_d.st   = ST_DONE;
                end else begin
                    r_d.pte = mem_rsp_data;
                    r_d.st  = ST_INST;
                end
            end
            ST_INST: begin
                tlb_wr_en = 1'b1;
                adv       = 1'b1;
                r_d.excv  = r_q.va;
                r_d.st    = ST_DONE;
                if (ring < r_q.priv)
                    r_d.code = (r_q.kind == ACC_FETCH) ? FLT_IPRIV : FLT_DPRIV;
                else if (!granted)
                    r_d.code = (r_q.kind == ACC_FETCH) ? FLT_FETCH_DENY :
                               (r_q.kind == ACC_STORE) ? FLT_STORE_DENY : FLT_LOAD_DENY;
                else
                    r_d.pa = tlb_wr_ppn | (r_q.va & ~PAGE_MASK);
            end
            ST_DONE: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.code <= FLT_NONE;
            r_q.kind <= ACC_LOAD;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy       = (r_q.st != ST_IDLE);
        mem_addr   = r_q.pte_pa;
        excvaddr   = r_q.excv;
        fault_code = r_q.code;
        paddr      = r_q.pa;
    end

    a_r1_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r2_lookup_single: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> !lkp_valid);
    a_r3_req_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(lkp_valid && lkp_hit));
    a_r4_write_needs_good_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |-> $past(mem_rsp_valid && !mem_rsp_err));
    a_r7_excv_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |=> excvaddr == $past(r_q.va));
    a_r11_paddr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == FLT_NONE) |->
            paddr[PAGE_BITS-1:0] == excvaddr[PAGE_BITS-1:0]);
endmodule

// File: tb/pte_refill_walker_bench.sv
`timescale 1ns/1ps
module pte_refill_walker_bench;
    localparam logic [31:0] OFS  = 32'h1000_0000;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_priv = '0;
    logic [31:0] pt_base = BASE;
    logic [31:0] rasid = 32'h4433_2211;
    logic        busy, lkp_valid, lkp_hit, mem_req;
    logic [31:0] lkp_vaddr, lkp_paddr, mem_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        tlb_wr_en, done;
    logic [1:0]  tlb_wr_way;
    logic [31:0] tlb_wr_vpn, tlb_wr_ppn, excvaddr, paddr;
    logic [7:0]  tlb_wr_asid;
    logic [3:0]  tlb_wr_attr;
    logic [2:0]  fault_code;

    logic        tb_hit = 1'b1;
    logic        tb_err = 1'b0;
    logic [31:0] tb_pte = '0;
    assign lkp_hit   = tb_hit;
    assign lkp_paddr = lkp_vaddr + OFS;

    pte_refill_walker u_pte_refill_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_priv(req_priv), .pt_base(pt_base), .rasid(rasid),
        .busy(busy), .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr), .lkp_hit(lkp_hit),
        .lkp_paddr(lkp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .tlb_wr_en(tlb_wr_en), .tlb_wr_way(tlb_wr_way),
        .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn), .tlb_wr_asid(tlb_wr_asid),
        .tlb_wr_attr(tlb_wr_attr), .excvaddr(excvaddr), .done(done),
        .fault_code(fault_code), .paddr(paddr)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    typedef struct {
        string       tag;
        logic [2:0]  code;
        logic [31:0] pa;
    } res_t;
    typedef struct {
        logic [1:0]  way;
        logic [31:0] vpn;
        logic [31:0] ppn;
        logic [7:0]  asid;
        logic [3:0]  attr;
    } wr_t;
    res_t res_q[$];
    wr_t  wr_q[$];

    logic [31:0] exp_lkp = '0;
    logic [31:0] exp_mem = '0;
    logic        mem_expected = 1'b0;
    int          tb_way = 0;
    logic [31:0] tb_exc = '0;

    // monitor: lookup address, refill writes, results
    always @(negedge clk) begin
        if (rst_n) begin
            if (lkp_valid) chk("R2 lookup address", lkp_vaddr, exp_lkp);
            if (tlb_wr_en) begin
                if (wr_q.size() == 0) begin
                    chk("R3 unexpected refill write", 32'd1, 32'd0);
                end else begin
                    wr_t w;
                    w = wr_q.pop_front();
                    chk("R6 refill way", 32'(tlb_wr_way), 32'(w.way));
                    chk("R5 refill vpn", tlb_wr_vpn, w.vpn);
                    chk("R5 refill ppn", tlb_wr_ppn, w.ppn);
                    chk("R5 refill asid", 32'(tlb_wr_asid), 32'(w.asid));
                    chk("R5 refill attr", 32'(tlb_wr_attr), 32'(w.attr));
                end
            end
            if (done) begin
                if (res_q.size() == 0) begin
                    chk("R1 unexpected result", 32'd1, 32'd0);
                end else begin
                    res_t r;
                    r = res_q.pop_front();
                    chk({r.tag, " fault code"}, 32'(fault_code), 32'(r.code));
                    if (r.code == 3'd0) chk({r.tag, " paddr"}, paddr, r.pa);
                end
            end
        end
    end

    // memory model: one response, one cycle after each request
    always begin
        @(negedge clk);
        if (rst_n && mem_req) begin
            chk("R4 entry read address", mem_addr, exp_mem);
            if (!mem_expected) chk("R3 unexpected memory read", 32'd1, 32'd0);
            @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = tb_pte;
            mem_rsp_err   = tb_err;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end
    end

    task automatic walk(string tag, int kind, int priv, logic [31:0] va,
                        logic [31:0] pte, bit hit, bit err, bit poke);
        res_t r;
        logic [1:0] ring;
        logic [3:0] attr;
        bit rd, wr, ex, ok;
        exp_lkp = (BASE | (va >> 10)) & 32'hFFFF_FFFC;
        exp_mem = exp_lkp + OFS;
        mem_expected = hit;
        tb_hit = hit;
        tb_err = err;
        tb_pte = pte;
        r.tag = tag;
        r.pa  = '0;
        if (!hit || err) begin
            r.code = (kind == 2) ? 3'd1 : 3'd2;
        end else begin
            wr_t w;
            tb_way = (tb_way + 1) % 4;
            ring   = pte[5:4];
            attr   = pte[3:0];
            w.way  = 2'(tb_way);
            w.vpn  = va & 32'hFFFF_F000;
            w.ppn  = pte & 32'hFFFF_F000;
            w.asid = 8'(rasid >> (32'(ring) * 8));
            w.attr = attr;
            wr_q.push_back(w);
            tb_exc = va;
            rd = (attr < 12) || (attr == 13);
            wr = ((attr < 12) && attr[1]) || (attr == 13);
            ex = (attr < 12) && attr[0];
            ok = (kind == 0) ? rd : (kind == 1) ? wr : ex;
            if (32'(ring) < 32'(priv)) r.code = (kind == 2) ? 3'd3 : 3'd4;
            else if (!ok) r.code = (kind == 2) ? 3'd7 : (kind == 1) ? 3'd6 : 3'd5;
            else begin
                r.code = 3'd0;
                r.pa = (pte & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
            end
        end
        res_q.push_back(r);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = 2'(kind);
        req_priv  = 2'(priv);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            chk("R1 busy after accept", 32'(busy), 32'd1);
            req_valid = 1'b1;
            req_vaddr = va ^ 32'h0F0F_0000;
            req_kind  = 2'd2;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R1 idle after result", 32'(busy), 32'd0);
        chk("R7 exception address", excvaddr, tb_exc);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R7 reset excvaddr", excvaddr, 32'd0);
        chk("R3 reset write strobe", 32'(tlb_wr_en), 32'd0);

        // R11 load granted, read-only attribute 4, way 1
        walk("R11 load ok", 0, 0, 32'h1234_5678, 32'hABCD_E014, 1, 0, 0);
        // R9 store on read-only attribute, way 2
        walk("R9 store denied", 1, 0, 32'h0040_1ABC, 32'h0055_5004, 1, 0, 0);
        walk("R9 store ok", 1, 1, 32'h0040_2FFF, 32'h0066_6016, 1, 0, 0);
        walk("R9 fetch ok", 2, 0, 32'h7000_0004, 32'h0077_7005, 1, 0, 0);
        walk("R9 fetch denied", 2, 0, 32'h7000_1000, 32'h0088_8006, 1, 0, 0);
        walk("R9 attr13 load", 0, 0, 32'h3000_0010, 32'h0099_900D, 1, 0, 0);
        walk("R9 attr13 store", 1, 0, 32'h3000_1020, 32'h0099_A00D, 1, 0, 0);
        walk("R9 attr13 fetch", 2, 0, 32'h3000_2030, 32'h0099_B00D, 1, 0, 0);
        walk("R9 attr12 load", 0, 0, 32'h3000_3040, 32'h0099_C00C, 1, 0, 0);
        walk("R9 attr15 load", 0, 0, 32'h3000_4050, 32'h0099_D00F, 1, 0, 0);
        // R10 side masking
        walk("R10 fetch ignores rw", 2, 0, 32'h5000_0100, 32'h00AA_A002, 1, 0, 0);
        walk("R10 load ignores x", 0, 0, 32'h5000_1100, 32'h00AA_B001, 1, 0, 0);
        walk("R10 store needs w", 1, 0, 32'h5000_2100, 32'h00AA_C001, 1, 0, 0);
        // R8 privilege before rights
        walk("R8 data priv", 0, 2, 32'h6000_0200, 32'h00BB_B013, 1, 0, 0);
        walk("R8 fetch priv", 2, 1, 32'h6000_1200, 32'h00BB_C00C, 1, 0, 0);
        walk("R8 equal ring ok", 0, 3, 32'h6000_2200, 32'h00BB_D034, 1, 0, 0);
        // R5 asid selection by ring 2
        walk("R5 asid ring2", 0, 0, 32'h6000_3300, 32'h00CC_C024, 1, 0, 0);
        // R3 lookup miss, R4 memory error
        walk("R3 load lookup miss", 0, 0, 32'hDEAD_B000, 32'h0, 0, 0, 0);
        walk("R3 fetch lookup miss", 2, 0, 32'hDEAD_C000, 32'h0, 0, 0, 0);
        walk("R4 read error", 1, 0, 32'hBEEF_0000, 32'h00DD_D016, 1, 1, 0);
        walk("R4 fetch read error", 2, 0, 32'hBEEF_1000, 32'h00DD_E015, 1, 1, 0);
        // R1 request while busy is ignored; R6 continues after non-refill walks
        walk("R1 poke while busy", 0, 0, 32'h2222_3333, 32'h00EE_E004, 1, 0, 1);
        walk("R6 next way", 0, 0, 32'h2222_4444, 32'h00EF_0004, 1, 0, 0);

        repeat (4) @(negedge clk);
        chk("R1 no pending results", 32'(res_q.size()), 32'd0);
        chk("R6 no pending writes", 32'(wr_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule